// File: doc/BRIEF.md
# Instruction Fetch Execute-Permission Checker

This block sits behind a first-stage address translation lookup and rules on whether an instruction fetch may proceed. It takes the access-permission and execute-never fields of the descriptor the lookup returned, the lookup level that produced it, the privilege of the fetch, and a global control bit that makes writable memory non-executable. It decides allow or fault in the same cycle, and registers that decision together with a fault syndrome one cycle later.

The syndrome has two parts. The first is an exception class for an instruction abort taken with no change of privilege level. The second is a permission status code that carries the lookup level. A fetch pipeline drives a valid strobe with the descriptor fields and reads the registered result on the following cycle.

Top module: `ifetch_perm_chk`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `fault_q` is 0 and `allow_q` is 0.
- R2: Permission encoding: `ap[1]`=1 grants unprivileged access. `ap[0]`=0 marks the region read/write, and `ap[0]`=1 marks it read-only. The region is privileged-writable when `ap[0]`=0. It is unprivileged-writable when `ap[1]`=1 and `ap[0]`=0.
- R3: With `wxn`=0, an unprivileged fetch (`priv`=0) faults exactly when `uxn`=1, and a privileged fetch (`priv`=1) faults exactly when `pxn`=1. The execute-never bit of the other privilege level has no effect.
- R4: With `wxn`=1, an unprivileged fetch also faults when the region is unprivileged-writable, even if `uxn`=0.
- R5: With `wxn`=1, a privileged fetch also faults when the region is privileged-writable, even if `pxn`=0.
- R6: One cycle after a cycle with `fetch_vld`=1, `fault_q` shows that cycle's fault decision and `allow_q` shows its inverse.
- R7: One cycle after a cycle with `fetch_vld`=0, `fault_q` and `allow_q` are both 0, and `syn_ec`/`syn_fsc` keep their previous values.
- R8: On a registered fault, `syn_ec` is 6'b100001 and `syn_fsc` is {4'b0011, level}, so level 3 gives 6'b001111 and level 0 gives 6'b001100.
- R9: The combinational `fault_now` output equals the current-cycle decision whenever `fetch_vld`=1, and is 0 whenever `fetch_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Fetch request valid |
| ap | input | 2 | Access permission: [1] unprivileged access, [0] read-only |
| uxn | input | 1 | Descriptor unprivileged execute-never |
| pxn | input | 1 | Descriptor privileged execute-never |
| level | input | 2 | Lookup level that produced the descriptor |
| priv | input | 1 | Fetch privilege: 1 privileged, 0 unprivileged |
| wxn | input | 1 | Write-implies-execute-never control |
| fault_now | output | 1 | Combinational fault decision |
| allow_q | output | 1 | Registered: last valid fetch allowed |
| fault_q | output | 1 | Registered: last valid fetch faulted |
| syn_ec | output | 6 | Registered exception class |
| syn_fsc | output | 6 | Registered fault status code |

## Verification
A wrong writability decode or a wrong level selection would show as a mismatch on `fault_now` in the same cycle, and on `fault_q` one edge later, for the specific permission combination involved. The full sweep covers every input pattern, so each such error is found within one check. A stuck or wrongly enabled syndrome register shows up as a wrong `syn_fsc` on the next fault, or as a syndrome that changes after an idle cycle.

// File: rtl/ifetch_perm_pkg.sv
package ifetch_perm_pkg;
  localparam int unsigned EC_W    = 6;
  localparam int unsigned FSC_W   = 6;
  localparam int unsigned LVL_W   = 2;
  localparam int unsigned AP_W    = 2;
  localparam logic [EC_W-1:0] EC_IABT_SAME = 6'b100001;
  localparam logic [FSC_W-LVL_W-1:0] FSC_PERM_PFX = 4'b0011;

  typedef struct packed {
    logic [EC_W-1:0]  ec;
    logic [FSC_W-1:0] fsc;
  } syndrome_t;
endpackage

// File: rtl/ifetch_wr_decode.sv
module ifetch_wr_decode
  import ifetch_perm_pkg::*;
(
  input  logic [AP_W-1:0] ap,
  output logic            wr_priv,
  output logic            wr_unpriv
);
  always_comb begin
    wr_priv   = ~ap[0];
    wr_unpriv = ap[1] & ~ap[0];
  end
endmodule

// File: rtl/ifetch_xn_eval.sv
module ifetch_xn_eval (
  input  logic wxn,
  input  logic priv,
  input  logic uxn,
  input  logic pxn,
  input  logic wr_priv,
  input  logic wr_unpriv,
  output logic deny
);
  logic eff_uxn, eff_pxn;
  always_comb begin
    eff_uxn = uxn | (wxn & wr_unpriv);
    eff_pxn = pxn | (wxn & wr_priv);
    deny    = priv ? eff_pxn : eff_uxn;
  end
endmodule

// File: rtl/ifetch_syn_reg.sv
module ifetch_syn_reg
  import ifetch_perm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic             deny,
  input  logic [LVL_W-1:0] level,
  output logic             allow_q,
  output logic             fault_q,
  output syndrome_t        syn_q
);
  logic      allow_d, fault_d, syn_en;
  syndrome_t syn_d;

  always_comb begin
    allow_d = vld & ~deny;
    fault_d = vld & deny;
    syn_en  = vld & deny;
    syn_d.ec  = EC_IABT_SAME;
    syn_d.fsc = {FSC_PERM_PFX, level};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      allow_q <= allow_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syn_q <= '0;
    else if (syn_en) syn_q <= syn_d;
  end

  // R6
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(allow_q && fault_q));
  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> (!allow_q && !fault_q));
  // R7
  syn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(syn_q));
  // R8
  syn_ec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> syn_q.ec == EC_IABT_SAME);
endmodule

// File: rtl/ifetch_perm_chk.sv
module ifetch_perm_chk
  import ifetch_perm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_vld,
  input  logic [AP_W-1:0]  ap,
  input  logic             uxn,
  input  logic             pxn,
  input  logic [LVL_W-1:0] level,
  input  logic             priv,
  input  logic             wxn,
  output logic             fault_now,
  output logic             allow_q,
  output logic             fault_q,
  output logic [EC_W-1:0]  syn_ec,
  output logic [FSC_W-1:0] syn_fsc
);
  logic      wr_priv, wr_unpriv, deny;
  syndrome_t syn_q;

  ifetch_wr_decode u_dec (.ap(ap), .wr_priv(wr_priv), .wr_unpriv(wr_unpriv));

  ifetch_xn_eval u_xn (
    .wxn(wxn), .priv(priv), .uxn(uxn), .pxn(pxn),
    .wr_priv(wr_priv), .wr_unpriv(wr_unpriv), .deny(deny)
  );

  ifetch_syn_reg u_reg (
    .clk(clk), .rst_n(rst_n), .vld(fetch_vld), .deny(deny), .level(level),
    .allow_q(allow_q), .fault_q(fault_q), .syn_q(syn_q)
  );

  always_comb begin
    fault_now = fetch_vld & deny;
    syn_ec    = syn_q.ec;
    syn_fsc   = syn_q.fsc;
  end

  // R6
  fault_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |=> fault_q == $past(fault_now));
  // R8
  fsc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> syn_fsc == {FSC_PERM_PFX, $past(level)});
  // R3
  priv_ignores_uxn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && priv && !pxn && !wxn) |-> !fault_now);
  // R4
  wxn_unpriv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && !priv && wxn && ap == 2'b10) |-> fault_now);
  // R5
  wxn_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && priv && wxn && !ap[0]) |-> fault_now);
endmodule

// File: tb/sim_ifetch_perm_chk.sv
`timescale 1ns/1ps
module sim_ifetch_perm_chk;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_vld = 1'b0, uxn = 1'b0, pxn = 1'b0, priv = 1'b0, wxn = 1'b0;
  logic [1:0] ap = 2'b00, level = 2'b00;
  logic fault_now, allow_q, fault_q;
  logic [5:0] syn_ec, syn_fsc;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ifetch_perm_chk u0 (.*);

  function automatic logic ref_deny(logic [1:0] a, logic u, logic p, logic pr, logic w);
    logic wp, wu;
    wp = ~a[0];
    wu = a[1] & ~a[0];
    return pr ? (p | (w & wp)) : (u | (w & wu));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [1:0] a, logic u, logic p, logic [1:0] l, logic pr, logic w);
    fetch_vld = v; ap = a; uxn = u; pxn = p; level = l; priv = pr; wxn = w;
  endtask

  task automatic t_reset;
    chk("R1 fault in reset", fault_q, 0);
    chk("R1 allow in reset", allow_q, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 fault after release", fault_q, 0);
    chk("R1 allow after release", allow_q, 0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 256; i++) begin
      logic exp;
      drive(1'b1, i[1:0], i[2], i[3], i[5:4], i[6], i[7]);
      exp = ref_deny(i[1:0], i[2], i[3], i[6], i[7]);
      #1;
      chk("R2 R3 R4 R5 R9 fault_now", fault_now, exp);
      @(negedge clk);
      chk("R6 fault_q", fault_q, exp);
      chk("R6 allow_q", allow_q, !exp);
      if (exp) begin
        chk("R8 ec", syn_ec, 6'b100001);
        chk("R8 fsc", syn_fsc, {4'b0011, i[5:4]});
      end
    end
  endtask

  task automatic t_directed;
    drive(1'b1, 2'b10, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1); #1;
    chk("R4 unpriv writable wxn", fault_now, 1);
    drive(1'b1, 2'b10, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0); #1;
    chk("R3 wxn off allows", fault_now, 0);
    drive(1'b1, 2'b00, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1); #1;
    chk("R2 ap=00 not unpriv writable", fault_now, 0);
    drive(1'b1, 2'b01, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1); #1;
    chk("R3 priv ignores uxn, read-only", fault_now, 0);
    drive(1'b1, 2'b00, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1); #1;
    chk("R5 priv writable wxn", fault_now, 1);
    @(negedge clk);
    chk("R8 fsc level3", syn_fsc, 6'b001111);
    drive(1'b1, 2'b00, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R8 fsc level0", syn_fsc, 6'b001100);
  endtask

  task automatic t_idle;
    drive(1'b1, 2'b00, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 fsc level2", syn_fsc, 6'b001110);
    drive(1'b0, 2'b00, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1); #1;
    chk("R9 idle fault_now", fault_now, 0);
    @(negedge clk);
    chk("R7 idle fault_q", fault_q, 0);
    chk("R7 idle allow_q", allow_q, 0);
    chk("R7 idle syn_fsc held", syn_fsc, 6'b001110);
    chk("R7 idle syn_ec held", syn_ec, 6'b100001);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sweep();
        t_directed();
        t_idle();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule